// File: doc/BRIEF.md
# Region-Protected Byte RAM

This block is a byte-wide synchronous RAM for a small processor bus. The RAM is cut into equal regions, and a mask register holds one bit for each region. A write to a region whose bit is clear is dropped without notice. A write to a region whose bit is set stores the byte as usual. Reads are never masked.

The mask register sits on the same bus as a short run of byte addresses, so a task can always see which regions are open. It can be changed only while the processor's interrupt-disable level is high. This lets an interrupt handler or a scheduler decide which memory a task may touch, while the task itself cannot unlock more.

A build-time switch can turn all masking off, so the block acts as a plain RAM. A second switch gives startup code write access to the mask right after reset. That access lasts until the processor first raises its interrupt-disable level itself. The region size follows the RAM size. A 1 KB RAM has 16 regions of 64 bytes. A 4 KB RAM has 32 regions of 128 bytes.

Top module: `region_guard_ram`

## Requirements
- R1: The RAM answers at bus addresses 0 to 2**AddrW-1. With `rdEn` high, the addressed byte appears on `rdData` one clock later. A cycle without a read that hits the RAM or the mask leaves `rdData` at 0 one clock later.
- R2: The region index is the top address bits of the RAM. A 1 KB RAM (AddrW=10) has 16 regions of 64 bytes, indexed by address bits [9:6]. A 4 KB RAM (AddrW=12) has 32 regions of 128 bytes, indexed by bits [11:7].
- R3: With `wrEn` high on a RAM address whose region mask bit is 0, the write is dropped and the stored byte keeps its old value. When the bit is 1, the byte is stored.
- R4: The mask register is read and written as bytes at MaskBase (0xFF00) plus k, for k from 0 to regions/8-1. Bit j of byte k belongs to region 8k+j. A read of a mask byte returns it one clock later.
- R5: A mask byte write takes effect only when `intDisable` is high in that cycle, or when the startup grant of R8 is still active. Otherwise the write is ignored.
- R6: Reset, active-low and asynchronous on `rstN`, clears every mask bit, so all regions are protected, and drives `rdData` to 0.
- R7: With WriteProtect=0, every RAM write is stored, whatever the mask holds.
- R8: With BootUnlock=1, mask writes are accepted with `intDisable` low from reset until the first clock edge at which `intDisable` is high. After that, R5 applies with no grant. With BootUnlock=0 the grant never exists.
- R9: A read and a write to the same RAM location in the same cycle return the byte as it was before the write.
- R10: A bus address outside both the RAM range and the mask range has no effect when written and reads as 0. Mask byte numbers at or beyond regions/8 count as outside.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | BusAddrW (16) | Bus byte address |
| wrData | input | 8 | Byte to write |
| wrEn | input | 1 | Write strobe for this cycle |
| rdEn | input | 1 | Read strobe for this cycle |
| intDisable | input | 1 | Processor interrupt-disable level that unlocks the mask register |
| rdData | output | 8 | Read byte, one clock after the read strobe, else 0 |

## Verification
The assertions assume that every input is a known level across the rising edge. They also assume that `intDisable` is a plain level that the block only samples, and that the RAM and mask address windows do not overlap. The bench changes every input only on the falling edge and drives only 0 or 1. It keeps the windows at their default bases, so the one-clock read echo and the mask-stability properties always see settled values.

// File: rtl/region_guard_pkg.sv
package region_guard_pkg;

  // Strobes issued by the control to the datapath each cycle.
  typedef struct packed {
    logic ramWrite;   // store wrData at the RAM address
    logic ramRead;    // capture a RAM byte into the read register
    logic maskWrite;  // store wrData into the selected mask byte
    logic maskRead;   // capture a mask byte into the read register
  } guardStrobes_t;

  // Region index width follows the RAM size: 4 KB and up uses 32 regions.
  function automatic int regionBitsFor(input int addrW);
    return (addrW >= 12) ? 5 : 4;
  endfunction

endpackage

// File: rtl/region_guard_ctrl.sv
module region_guard_ctrl
  import region_guard_pkg::*;
#(
  parameter int                BusAddrW     = 16,
  parameter int                AddrW        = 10,
  parameter int                MaskIdxW     = 1,
  parameter logic [BusAddrW-1:0] RamBase    = '0,
  parameter logic [BusAddrW-1:0] MaskBase   = 16'hFF00,
  parameter bit                WriteProtect = 1'b1,
  parameter bit                BootUnlock   = 1'b0
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [BusAddrW-1:MaskIdxW]   hiAddr,
  input  logic                         wrEn,
  input  logic                         rdEn,
  input  logic                         intDisable,
  input  logic                         regionOpen,
  output guardStrobes_t                strobes,
  output logic                         bootGrant
);

  logic ramHit;
  logic maskHit;
  logic writeAllowed;
  logic maskUnlocked;

  // Window decode on the upper address bits only.
  assign ramHit  = (hiAddr[BusAddrW-1:AddrW] == RamBase[BusAddrW-1:AddrW]);
  assign maskHit = (hiAddr == MaskBase[BusAddrW-1:MaskIdxW]);

  // With protection off the region bit has no say.
  assign writeAllowed = !WriteProtect || regionOpen;

  // Startup grant: starts at BootUnlock, falls for good once the
  // processor raises its own interrupt-disable level.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bootGrant <= BootUnlock;
    end else if (intDisable) begin
      bootGrant <= 1'b0;
    end
  end

  assign maskUnlocked = intDisable || bootGrant;

  always_comb begin
    strobes           = '0;
    strobes.ramWrite  = wrEn && ramHit && writeAllowed;
    strobes.ramRead   = rdEn && ramHit;
    strobes.maskWrite = wrEn && maskHit && maskUnlocked;
    strobes.maskRead  = rdEn && maskHit;
  end

endmodule

// File: rtl/region_guard_datapath.sv
module region_guard_datapath
  import region_guard_pkg::*;
#(
  parameter int AddrW      = 10,
  parameter int RegionBits = 4,
  parameter int MaskIdxW   = 1,
  localparam int MemDepth  = 1 << AddrW,
  localparam int Regions   = 1 << RegionBits,
  localparam int MaskBytes = Regions / 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  guardStrobes_t       strobes,
  input  logic [AddrW-1:0]    ramAddr,
  input  logic [MaskIdxW-1:0] maskIdx,
  input  logic [7:0]          wrData,
  output logic                regionOpen,
  output logic [Regions-1:0]  maskVec,
  output logic [7:0]          rdData
);

  logic [7:0] mem [MemDepth];
  logic [7:0] maskByte [MaskBytes];

  // Storage array: no reset, written only when the control allows.
  always_ff @(posedge clk) begin
    if (strobes.ramWrite) begin
      mem[ramAddr] <= wrData;
    end
  end

  // Mask bytes: all clear (all protected) out of reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < MaskBytes; b++) begin
        maskByte[b] <= '0;
      end
    end else if (strobes.maskWrite) begin
      maskByte[maskIdx] <= wrData;
    end
  end

  for (genvar b = 0; b < MaskBytes; b++) begin : gMaskFlat
    assign maskVec[8*b +: 8] = maskByte[b];
  end

  // Region of the current address, taken from its top bits.
  assign regionOpen = maskVec[ramAddr[AddrW-1 -: RegionBits]];

  // Read register: old contents on a same-cycle write, 0 when idle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobes.ramRead) begin
      rdData <= mem[ramAddr];
    end else if (strobes.maskRead) begin
      rdData <= maskByte[maskIdx];
    end else begin
      rdData <= '0;
    end
  end

endmodule

// File: rtl/region_guard_ram.sv
module region_guard_ram
  import region_guard_pkg::*;
#(
  parameter int                  BusAddrW     = 16,
  parameter int                  AddrW        = 10,
  parameter logic [BusAddrW-1:0] RamBase      = '0,
  parameter logic [BusAddrW-1:0] MaskBase     = 16'hFF00,
  parameter bit                  WriteProtect = 1'b1,
  parameter bit                  BootUnlock   = 1'b0,
  localparam int RegionBits = regionBitsFor(AddrW),
  localparam int Regions    = 1 << RegionBits,
  localparam int MaskBytes  = Regions / 8,
  localparam int MaskIdxW   = (MaskBytes > 1) ? $clog2(MaskBytes) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [BusAddrW-1:0] busAddr,
  input  logic [7:0]          wrData,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic                intDisable,
  output logic [7:0]          rdData
);

  guardStrobes_t      strobes;
  logic               regionOpen;
  logic               bootGrant;
  logic [Regions-1:0] maskVec;

  region_guard_ctrl #(
    .BusAddrW    (BusAddrW),
    .AddrW       (AddrW),
    .MaskIdxW    (MaskIdxW),
    .RamBase     (RamBase),
    .MaskBase    (MaskBase),
    .WriteProtect(WriteProtect),
    .BootUnlock  (BootUnlock)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .hiAddr     (busAddr[BusAddrW-1:MaskIdxW]),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .intDisable (intDisable),
    .regionOpen (regionOpen),
    .strobes    (strobes),
    .bootGrant  (bootGrant)
  );

  region_guard_datapath #(
    .AddrW      (AddrW),
    .RegionBits (RegionBits),
    .MaskIdxW   (MaskIdxW)
  ) uDatapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .ramAddr    (busAddr[AddrW-1:0]),
    .maskIdx    (busAddr[MaskIdxW-1:0]),
    .wrData     (wrData),
    .regionOpen (regionOpen),
    .maskVec    (maskVec),
    .rdData     (rdData)
  );

endmodule

// File: rtl/region_guard_ram_chk.sv
module region_guard_ram_chk #(
  parameter int                  BusAddrW = 16,
  parameter int                  Regions  = 16,
  parameter int                  MaskIdxW = 1,
  parameter logic [BusAddrW-1:0] MaskBase = 16'hFF00
) (
  input logic                clk,
  input logic                rstN,
  input logic [BusAddrW-1:0] busAddr,
  input logic                wrEn,
  input logic                rdEn,
  input logic                intDisable,
  input logic [7:0]          rdData,
  input logic [Regions-1:0]  maskVec,
  input logic                bootGrant
);

  logic       maskAddrHit;
  logic [7:0] maskByteNow;

  assign maskAddrHit = (busAddr[BusAddrW-1:MaskIdxW] == MaskBase[BusAddrW-1:MaskIdxW]);
  assign maskByteNow = 8'(maskVec >> {busAddr[MaskIdxW-1:0], 3'b000});

  AST_IDLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> (rdData == 8'h00)); // R1

  AST_MASK_READ_ECHO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && maskAddrHit) |=> (rdData == $past(maskByteNow))); // R4

  AST_MASK_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && maskAddrHit && !intDisable && !bootGrant) |=> $stable(maskVec)); // R5

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (maskVec == '0 && rdData == 8'h00)); // R6

  AST_BOOT_ONE_WAY: assert property (@(posedge clk) disable iff (!rstN)
    !bootGrant |=> !bootGrant); // R8

  AST_BOOT_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    intDisable |=> !bootGrant); // R8

endmodule

bind region_guard_ram region_guard_ram_chk #(
  .BusAddrW (BusAddrW),
  .Regions  (Regions),
  .MaskIdxW (MaskIdxW),
  .MaskBase (MaskBase)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .busAddr    (busAddr),
  .wrEn       (wrEn),
  .rdEn       (rdEn),
  .intDisable (intDisable),
  .rdData     (rdData),
  .maskVec    (maskVec),
  .bootGrant  (bootGrant)
);

// File: tb/region_guard_ram_test.sv
`timescale 1ns/1ps
module region_guard_ram_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0]  wrData = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic        intDisable = 1'b0;
  logic [7:0]  rdProt, rdOpen, rdBoot;

  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;
  string curReq = "R6";

  always #2 clk = ~clk;

  // Three builds: protected 1 KB, unprotected 1 KB, 4 KB with startup grant.
  region_guard_ram #(.AddrW(10), .WriteProtect(1'b1), .BootUnlock(1'b0)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .intDisable(intDisable), .rdData(rdProt));
  region_guard_ram #(.AddrW(10), .WriteProtect(1'b0), .BootUnlock(1'b0)) uutOpen (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .intDisable(intDisable), .rdData(rdOpen));
  region_guard_ram #(.AddrW(12), .WriteProtect(1'b1), .BootUnlock(1'b1)) uutBoot (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .intDisable(intDisable), .rdData(rdBoot));

  // Behavioural reference state per build.
  int         cfgAw   [3] = '{10, 10, 12};
  bit         cfgWp   [3] = '{1'b1, 1'b0, 1'b1};
  bit         cfgBoot [3] = '{1'b0, 1'b0, 1'b1};
  logic [7:0] memRef   [3][4096];
  bit         memKnown [3][4096];
  logic [31:0] maskRef [3];
  bit         bootRef  [3];
  logic [7:0] expRd    [3];
  bit         expKnown [3];

  function automatic logic [7:0] actualRd(input int i);
    return (i == 0) ? rdProt : (i == 1) ? rdOpen : rdBoot;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 3; i++) begin
      maskRef[i] = '0;
      bootRef[i] = cfgBoot[i];
      expRd[i] = 8'h00;
      expKnown[i] = 1'b1;
      for (int a = 0; a < 4096; a++) memKnown[i][a] = 1'b0;
    end
  endtask

  task automatic modelStep();
    for (int i = 0; i < 3; i++) begin
      int  size  = 1 << cfgAw[i];
      int  rbits = (cfgAw[i] >= 12) ? 5 : 4;
      int  nb    = (1 << rbits) / 8;
      int  a     = int'(busAddr);
      bit  ramHit  = a < size;
      bit  maskHit = (a >= 'hFF00) && (a < 'hFF00 + nb);
      int  region  = a >> (cfgAw[i] - rbits);
      bit  allow   = !cfgWp[i] || maskRef[i][region];
      if (rdEn && ramHit) begin
        expRd[i] = memRef[i][a];
        expKnown[i] = memKnown[i][a];
      end else if (rdEn && maskHit) begin
        expRd[i] = 8'(maskRef[i] >> (8 * (a - 'hFF00)));
        expKnown[i] = 1'b1;
      end else begin
        expRd[i] = 8'h00;
        expKnown[i] = 1'b1;
      end
      if (wrEn && ramHit && allow) begin
        memRef[i][a] = wrData;
        memKnown[i][a] = 1'b1;
      end
      if (wrEn && maskHit && (intDisable || bootRef[i])) begin
        maskRef[i][8*(a - 'hFF00) +: 8] = wrData;
      end
      if (intDisable) bootRef[i] = 1'b0;
    end
  endtask

  task automatic compareAll();
    for (int i = 0; i < 3; i++) begin
      if (expKnown[i]) begin
        checks++;
        if (actualRd(i) !== expRd[i]) begin
          fails++;
          $display("FAIL %s build %0d: rdData actual %02h expected %02h (addr %04h)",
                   curReq, i, actualRd(i), expRd[i], busAddr);
        end
      end
    end
  endtask

  // One bus cycle: drive, clock, step the model, sample at the falling edge.
  task automatic cyc(input logic [15:0] a, input logic [7:0] d,
                     input bit we, input bit re, input bit id);
    busAddr = a; wrData = d; wrEn = we; rdEn = re; intDisable = id;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic rd(input logic [15:0] a, input bit id);
    cyc(a, 8'h00, 1'b0, 1'b1, id);
    cyc(16'h4000, 8'h00, 1'b0, 1'b0, id);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input bit id);
    cyc(a, d, 1'b1, 1'b0, id);
  endtask

  logic [15:0] probe [10] = '{16'h0000, 16'h0010, 16'h003F, 16'h0040, 16'h007F,
                              16'h0080, 16'h03C0, 16'h03FF, 16'h0780, 16'h0F80};

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    curReq = "R6";
    compareAll();
    rstN = 1'b1;
    // R6: all mask bytes read zero, idle read is zero
    for (int k = 0; k < 4; k++) rd(16'hFF00 + 16'(k), 1'b0);

    // R5 / R8: locked write with intDisable low; only the startup grant accepts it
    curReq = "R8";
    wr(16'hFF00, 8'hFF, 1'b0);
    rd(16'hFF00, 1'b0);
    // intDisable high: every build unlocks; grant ends here
    curReq = "R4";
    for (int k = 0; k < 4; k++) wr(16'hFF00 + 16'(k), 8'hFF, 1'b1);
    for (int k = 0; k < 4; k++) rd(16'hFF00 + 16'(k), 1'b1);
    // prefill probes with everything open
    curReq = "R1";
    foreach (probe[p]) wr(probe[p], 8'(probe[p] ^ 16'h5A), 1'b0);
    foreach (probe[p]) rd(probe[p], 1'b0);
    // R5: now locked, grant gone in every build
    curReq = "R5";
    wr(16'hFF00, 8'h00, 1'b0);
    rd(16'hFF00, 1'b0);
    curReq = "R8";
    wr(16'hFF01, 8'h00, 1'b0);
    rd(16'hFF01, 1'b0);

    // R3 / R7: close everything, then write
    curReq = "R3";
    for (int k = 0; k < 4; k++) wr(16'hFF00 + 16'(k), 8'h00, 1'b1);
    wr(16'h0010, 8'hC3, 1'b0);
    curReq = "R7";
    rd(16'h0010, 1'b0);

    // R2: only region 1 open -> 64..127 on 1 KB, 128..255 on 4 KB
    curReq = "R2";
    wr(16'hFF00, 8'h02, 1'b1);
    foreach (probe[p]) wr(probe[p], 8'(p + 8'h30), 1'b0);
    foreach (probe[p]) rd(probe[p], 1'b0);

    // R4: byte 1 bit 7 and byte 3 bit 7 (beyond the 1 KB window: R10)
    curReq = "R4";
    wr(16'hFF01, 8'h80, 1'b1);
    wr(16'hFF03, 8'h80, 1'b1);
    rd(16'hFF01, 1'b0);
    curReq = "R10";
    rd(16'hFF03, 1'b0);
    curReq = "R4";
    foreach (probe[p]) wr(probe[p], 8'(p + 8'hA0), 1'b0);
    foreach (probe[p]) rd(probe[p], 1'b0);

    // R9: same-cycle read and write of an open location
    curReq = "R9";
    wr(16'hFF00, 8'hFF, 1'b1);
    cyc(16'h0010, 8'h77, 1'b1, 1'b1, 1'b0);
    rd(16'h0010, 1'b0);

    // R10: out-of-window write must not alias onto address 0
    curReq = "R10";
    wr(16'h8000, 8'hEE, 1'b0);
    rd(16'h8000, 1'b0);
    rd(16'h0000, 1'b0);

    // R1: mixed traffic
    curReq = "R1";
    for (int n = 0; n < 600; n++) begin
      logic [15:0] a;
      case ($urandom % 4)
        0: a = probe[$urandom % 10];
        1: a = 16'($urandom % 4096);
        2: a = 16'hFF00 + 16'($urandom % 4);
        default: a = 16'($urandom);
      endcase
      cyc(a, 8'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4) == 0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule